// File: doc/BRIEF.md
# Pixel Bit-Depth Reducer with LFSR Spatial Dither

This block takes 12-bit-per-channel RGB pixels and narrows them to 6 or 8 significant bits per channel. The result is left-aligned in the 12-bit output word, and the dropped low bits are forced to zero. The narrowing is done either by plain truncation or by random spatial dithering. In the dithering mode, the low bits of a per-channel noise source are added to the pixel before the cut, and the sum saturates at full scale.

Each channel's noise comes from its own 28-bit linear feedback shift register. The register is loaded from a per-channel seed input and advances once for every valid pixel. In frame-random mode, the registers are reloaded at every frame-start strobe, and a 4-bit frame counter is mixed into the loaded value so that successive frames get different patterns. Outside that mode, the seeds are loaded only once, at the first frame-start after reset. A per-channel polynomial option gives green and blue their own feedback taps.

Top module: `pix_depth_reducer`

## Requirements
- R1: The depth code `depth_i` selects the output precision. Code 0 keeps the upper 6 bits of each channel and code 1 keeps the upper 8 bits. When reduction is active, the remaining low bits of the 12-bit output are zero.
- R2: With depth code 2 or 3, every channel is passed through unchanged, whatever the enables are set to.
- R3: With truncation enabled, dithering disabled and depth 0 or 1, each output is the input with its dropped low bits cleared.
- R4: With dithering enabled and depth 0 or 1, each output is (input + noise), saturated and then with its dropped bits cleared. The noise is the low 6 bits of the channel's LFSR state at depth 0, or the low 4 bits at depth 1. Dithering takes priority over truncation.
- R5: If input plus noise exceeds 4095, the sum is held at 4095 before the low bits are cleared. For example, 0xFFF at depth 0 gives 0xFC0.
- R6: With both enables clear, the output equals the input.
- R7: A channel's LFSR advances only in a cycle where `valid_i` is high and no load happens. The next state is {s[26:0], s[27] ^ s[k-1]}. With `chan_poly_i` low, k is 3 for all channels. With `chan_poly_i` high, k is 3 for red, 9 for green and 13 for blue. The LFSR holds its state in every other cycle.
- R8: After reset, every LFSR holds 1. With `frame_rand_i` low, the seeds are loaded only at the first `frame_start_i` after reset, and later strobes leave the LFSRs untouched.
- R9: With `frame_rand_i` high, every `frame_start_i` loads each LFSR with seed XOR (frame count << 8). The frame count used is the value held before that strobe.
- R10: The frame counter resets to 0. It increments on every `frame_start_i` and wraps from 15 to 0.
- R11: The output registers add one cycle of latency. `valid_o` is `valid_i` delayed by one cycle, and `valid_o` is 0 after reset.
- R12: A load value of zero is replaced by 1, so that the LFSR never locks up.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| trunc_en_i | input | 1 | Truncation enable |
| dith_en_i | input | 1 | Spatial dither enable (overrides truncation) |
| depth_i | input | 2 | 0: 6-bit, 1: 8-bit, 2/3: pass-through |
| chan_poly_i | input | 1 | Per-channel feedback taps |
| frame_rand_i | input | 1 | Reload LFSRs on every frame start |
| seed_r_i | input | 28 | Red LFSR seed |
| seed_g_i | input | 28 | Green LFSR seed |
| seed_b_i | input | 28 | Blue LFSR seed |
| frame_start_i | input | 1 | Frame start strobe |
| valid_i | input | 1 | Input pixel valid |
| pix_r_i | input | 12 | Red input |
| pix_g_i | input | 12 | Green input |
| pix_b_i | input | 12 | Blue input |
| valid_o | output | 1 | Output pixel valid |
| pix_r_o | output | 12 | Red output |
| pix_g_o | output | 12 | Green output |
| pix_b_o | output | 12 | Blue output |

## Verification
The bench builds the block with its default parameters: 12-bit pixels, 28-bit LFSRs, a 4-bit counter with a maximum of 15, and a mixing offset of bit 8. At these widths, a full sweep of all 4096 input codes through truncation at both depths is cheap. So is a bit-exact software model of all three LFSRs that follows every load and advance. Long dithered runs, a full wrap of the frame counter and a zero-seed load are each compared value by value against that model.

// File: rtl/pdr_pkg.sv
package pdr_pkg;
  localparam int NUM_CH   = 3;
  localparam int BASE_TAP = 3;

  // feedback tap used by channel ch when per-channel polynomials are selected
  function automatic int alt_tap(input int ch);
    case (ch)
      1:       return 9;
      2:       return 13;
      default: return 3;
    endcase
  endfunction
endpackage

// File: rtl/pdr_lfsr.sv
module pdr_lfsr #(
  parameter int W        = 28,
  parameter int TAP_BASE = 3,
  parameter int TAP_ALT  = 3
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         alt_i,
  input  logic         load_i,
  input  logic [W-1:0] seed_i,
  input  logic         adv_i,
  output logic [W-1:0] state_o
);
  logic [W-1:0] state_q;
  logic         fb;

  assign fb = state_q[W-1] ^ (alt_i ? state_q[TAP_ALT-1] : state_q[TAP_BASE-1]);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     state_q <= W'(1);
    else if (load_i) state_q <= (seed_i == '0) ? W'(1) : seed_i;
    else if (adv_i)  state_q <= {state_q[W-2:0], fb};
  end

  assign state_o = state_q;

  // R12
  lfsr_nonzero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni) state_q != '0);
  // R7
  lfsr_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && !adv_i) |=> $stable(state_q));
endmodule

// File: rtl/pdr_frame_ctr.sv
module pdr_frame_ctr #(
  parameter int W   = 4,
  parameter int MAX = 15
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         tick_i,
  output logic [W-1:0] cnt_o
);
  localparam logic [W-1:0] MAX_V = W'(MAX);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (tick_i) cnt_q <= (cnt_q == MAX_V) ? '0 : cnt_q + 1'b1;
  end

  assign cnt_o = cnt_q;

  // R10
  fcnt_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni) cnt_q <= MAX_V);
  // R10
  fcnt_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && cnt_q != MAX_V) |=> cnt_q == $past(cnt_q) + 1'b1);
endmodule

// File: rtl/pdr_reduce.sv
module pdr_reduce #(
  parameter int PIX_W    = 12,
  parameter int NARROW_W = 6,
  parameter int WIDE_W   = 8,
  localparam int NOISE_W = PIX_W - NARROW_W
) (
  input  logic [PIX_W-1:0]   pix_i,
  input  logic [NOISE_W-1:0] noise_i,
  input  logic               dith_en_i,
  input  logic               trunc_en_i,
  input  logic [1:0]         depth_i,
  output logic [PIX_W-1:0]   pix_o
);
  localparam logic [PIX_W-1:0] MASK_N = {{NARROW_W{1'b0}}, {NOISE_W{1'b1}}};
  localparam logic [PIX_W-1:0] MASK_W = {{WIDE_W{1'b0}}, {(PIX_W-WIDE_W){1'b1}}};

  logic [PIX_W-1:0] low_mask, noise_ext, sat;
  logic [PIX_W:0]   sum;
  logic             reducing;

  always_comb begin
    reducing = 1'b1;
    case (depth_i)
      2'd0:    low_mask = MASK_N;
      2'd1:    low_mask = MASK_W;
      default: begin low_mask = '0; reducing = 1'b0; end
    endcase
    noise_ext = {{NARROW_W{1'b0}}, noise_i} & low_mask;
    sum       = {1'b0, pix_i} + {1'b0, noise_ext};
    sat       = sum[PIX_W] ? '1 : sum[PIX_W-1:0];
    if (reducing && dith_en_i)       pix_o = sat & ~low_mask;
    else if (reducing && trunc_en_i) pix_o = pix_i & ~low_mask;
    else                             pix_o = pix_i;
  end
endmodule

// File: rtl/pix_depth_reducer.sv
module pix_depth_reducer #(
  parameter int PIX_W      = 12,
  parameter int LFSR_W     = 28,
  parameter int FCNT_W     = 4,
  parameter int FCNT_MAX   = 15,
  parameter int FRAME_SWAP = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              trunc_en_i,
  input  logic              dith_en_i,
  input  logic [1:0]        depth_i,
  input  logic              chan_poly_i,
  input  logic              frame_rand_i,
  input  logic [LFSR_W-1:0] seed_r_i,
  input  logic [LFSR_W-1:0] seed_g_i,
  input  logic [LFSR_W-1:0] seed_b_i,
  input  logic              frame_start_i,
  input  logic              valid_i,
  input  logic [PIX_W-1:0]  pix_r_i,
  input  logic [PIX_W-1:0]  pix_g_i,
  input  logic [PIX_W-1:0]  pix_b_i,
  output logic              valid_o,
  output logic [PIX_W-1:0]  pix_r_o,
  output logic [PIX_W-1:0]  pix_g_o,
  output logic [PIX_W-1:0]  pix_b_o
);
  import pdr_pkg::*;

  localparam int NARROW_W = 6;
  localparam int WIDE_W   = 8;
  localparam int NOISE_W  = PIX_W - NARROW_W;
  localparam int MIX_SH   = FCNT_W * FRAME_SWAP;

  logic [NUM_CH-1:0][LFSR_W-1:0] seeds;
  logic [NUM_CH-1:0][PIX_W-1:0]  pix_in, pix_red, pix_q;
  logic [FCNT_W-1:0]             fcnt;
  logic [LFSR_W-1:0]             fmix;
  logic                          started_q, load, adv;

  assign seeds  = {seed_b_i, seed_g_i, seed_r_i};
  assign pix_in = {pix_b_i, pix_g_i, pix_r_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            started_q <= 1'b0;
    else if (frame_start_i) started_q <= 1'b1;
  end

  assign load = frame_start_i && (frame_rand_i || !started_q);
  assign adv  = valid_i && !load;
  assign fmix = frame_rand_i ? ({{(LFSR_W-FCNT_W){1'b0}}, fcnt} << MIX_SH) : '0;

  pdr_frame_ctr #(.W(FCNT_W), .MAX(FCNT_MAX)) u_fcnt (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(frame_start_i), .cnt_o(fcnt)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    logic [LFSR_W-1:0] state;

    pdr_lfsr #(.W(LFSR_W), .TAP_BASE(BASE_TAP), .TAP_ALT(alt_tap(c))) u_lfsr (
      .clk_i(clk_i), .rst_ni(rst_ni), .alt_i(chan_poly_i), .load_i(load),
      .seed_i(seeds[c] ^ fmix), .adv_i(adv), .state_o(state)
    );

    pdr_reduce #(.PIX_W(PIX_W), .NARROW_W(NARROW_W), .WIDE_W(WIDE_W)) u_red (
      .pix_i(pix_in[c]), .noise_i(state[NOISE_W-1:0]), .dith_en_i(dith_en_i),
      .trunc_en_i(trunc_en_i), .depth_i(depth_i), .pix_o(pix_red[c])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      pix_q   <= '0;
    end else begin
      valid_o <= valid_i;
      pix_q   <= pix_red;
    end
  end

  assign pix_r_o = pix_q[0];
  assign pix_g_o = pix_q[1];
  assign pix_b_o = pix_q[2];

  // R11
  valid_delay_chk: assert property (@(posedge clk_i) disable iff (!rst_ni) valid_o == $past(valid_i));
  // R8
  started_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni) started_q |=> started_q);
endmodule

// File: tb/pix_depth_reducer_bench.sv
module pix_depth_reducer_bench;
  localparam int CLK_P = 10;

  logic clk = 0, rst_n = 0;
  logic trunc_en = 0, dith_en = 0, chan_poly = 0, frame_rand = 0, fs = 0, vld = 0;
  logic [1:0] depth = 0;
  logic [27:0] seed[3];
  logic [11:0] pin[3];
  logic valid_o;
  logic [11:0] pr_o, pg_o, pb_o;

  int checks = 0, fails = 0;
  bit done = 0;
  logic [27:0] m[3];
  int mcnt = 0;
  bit mstarted = 0;
  int lcg = 12345;

  always #(CLK_P/2) clk = ~clk;

  pix_depth_reducer u_pix_depth_reducer (
    .clk_i(clk), .rst_ni(rst_n), .trunc_en_i(trunc_en), .dith_en_i(dith_en),
    .depth_i(depth), .chan_poly_i(chan_poly), .frame_rand_i(frame_rand),
    .seed_r_i(seed[0]), .seed_g_i(seed[1]), .seed_b_i(seed[2]),
    .frame_start_i(fs), .valid_i(vld),
    .pix_r_i(pin[0]), .pix_g_i(pin[1]), .pix_b_i(pin[2]),
    .valid_o(valid_o), .pix_r_o(pr_o), .pix_g_o(pg_o), .pix_b_o(pb_o)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int tap(input int c);
    if (!chan_poly) return 3;
    return (c == 0) ? 3 : (c == 1) ? 9 : 13;
  endfunction

  function automatic logic [27:0] nxt(input logic [27:0] s, input int k);
    return {s[26:0], s[27] ^ s[k-1]};
  endfunction

  function automatic int expv(input int p, input int n);
    int drop, msk, s;
    if (depth > 1) return p;
    drop = (depth == 0) ? 6 : 4;
    msk  = (1 << drop) - 1;
    if (dith_en) begin
      s = p + (n & msk);
      if (s > 4095) s = 4095;
      return s & ~msk & 12'hFFF;
    end
    if (trunc_en) return p & ~msk & 12'hFFF;
    return p;
  endfunction

  function automatic int rnd();
    lcg = (lcg * 1103515245 + 12345) & 32'h7FFFFFFF;
    return (lcg >> 8) & 12'hFFF;
  endfunction

  task automatic send(input int r, input int g, input int b, input string req);
    int e[3];
    int v[3];
    v[0] = r; v[1] = g; v[2] = b;
    @(negedge clk);
    vld = 1;
    for (int c = 0; c < 3; c++) begin
      pin[c] = 12'(v[c]);
      e[c] = expv(v[c], int'(m[c][5:0]));
      m[c] = nxt(m[c], tap(c));
    end
    @(negedge clk);
    vld = 0;
    chk({req, " R11 valid"}, int'(valid_o), 1);
    chk({req, " red"}, int'(pr_o), e[0]);
    chk({req, " green"}, int'(pg_o), e[1]);
    chk({req, " blue"}, int'(pb_o), e[2]);
  endtask

  task automatic frame();
    @(negedge clk);
    fs = 1;
    for (int c = 0; c < 3; c++) begin
      logic [27:0] lv;
      lv = seed[c] ^ (frame_rand ? (28'(mcnt) << 8) : 28'd0);
      if (frame_rand || !mstarted) m[c] = (lv == 0) ? 28'd1 : lv;
    end
    mstarted = 1;
    mcnt = (mcnt == 15) ? 0 : mcnt + 1;
    @(negedge clk);
    fs = 0;
  endtask

  initial begin
    #(CLK_P * 150000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    seed[0] = 28'h5A3C_F19; seed[1] = 28'hB07_2E4D; seed[2] = 28'h0F1_E2D3;
    for (int c = 0; c < 3; c++) begin pin[c] = 0; m[c] = 28'd1; end
    repeat (3) @(negedge clk);
    chk("R11 reset valid", int'(valid_o), 0);
    chk("R11 reset data", int'(pr_o), 0);
    rst_n = 1;

    // R3 R1 exhaustive truncation at both depths
    trunc_en = 1;
    for (int d = 0; d < 2; d++) begin
      depth = 2'(d);
      for (int p = 0; p < 4096; p++) send(p, 4095 - p, (p * 7) & 4095, "R3 R1 trunc");
    end
    // R6 no enables
    trunc_en = 0; depth = 0;
    for (int i = 0; i < 64; i++) send(rnd(), rnd(), rnd(), "R6 pass");
    // R2 unsupported depths with enables set
    trunc_en = 1; dith_en = 1;
    for (int d = 2; d < 4; d++) begin
      depth = 2'(d);
      for (int i = 0; i < 64; i++) send(rnd(), rnd(), rnd(), "R2 bypass");
    end
    // R8 startup load, then R4 R7 dither with shared taps
    depth = 0;
    frame();
    for (int i = 0; i < 600; i++) send(rnd(), rnd(), rnd(), "R4 R7 R8 dither6");
    seed[0] = 28'h1234567;
    frame();   // ignored: R8
    for (int i = 0; i < 100; i++) send(rnd(), rnd(), rnd(), "R8 no reload");
    // R7 per-channel taps, 8-bit depth
    chan_poly = 1; depth = 1;
    for (int i = 0; i < 600; i++) send(rnd(), rnd(), rnd(), "R7 R4 dither8");
    // R5 saturation
    depth = 0;
    for (int i = 0; i < 40; i++) send(4095, 4032 + (i & 63), 4090, "R5 sat");
    depth = 1;
    for (int i = 0; i < 40; i++) send(4095, 4080 + (i & 15), 4094, "R5 sat8");
    // R9 R10 frame-random reloads across a full counter wrap
    frame_rand = 1; depth = 0;
    for (int f = 0; f < 18; f++) begin
      frame();
      for (int i = 0; i < 4; i++) send(rnd(), rnd(), rnd(), "R9 R10 frame rand");
    end
    // R12 zero load value
    while (mcnt != 0) frame();
    seed[0] = 0;
    frame();
    send(100, 200, 300, "R12 zero seed");
    for (int i = 0; i < 40; i++) send(rnd(), rnd(), rnd(), "R12 after zero");

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule